// File: doc/BRIEF.md
# Interrupt Acknowledge Vector Sequencer

This block answers the processor's interrupt acknowledge pulses for an eight-input interrupt controller. It counts the pulses of one acknowledge sequence. For each pulse it decides whether to drive the shared data bus, and what byte to drive. Two bus styles are supported. In call style a sequence has three pulses, which carry an opcode byte, then the low byte of a vector address, then the high byte. In pointer style a sequence has two pulses. The first leaves the bus undriven and the second carries an 8-bit pointer.

The block also takes part in cascaded systems. As the master, it puts the number of the winning input on the 3-bit cascade lines when a subordinate controller hangs off that input. As a subordinate, it compares the cascade lines against its own identifier before it drives any vector byte. The block tells the priority resolver when to mark the winning level as in service and when to retire it automatically. The winning level itself is supplied by the resolver, and the configuration comes from a separate programming block.

The acknowledge input `ack_n` is active low and is treated as a synchronous level. A pulse begins on the cycle where `ack_n` is first seen low, and ends on the cycle where it is first seen high again.

Top module: `ack_vector_seq`

## Requirements
- R1: In call style (`ptr_mode`=0), a controller that is not a subordinate drives 8'hCD with `dout_oe`=1 during every low cycle of the first pulse. While `dout_oe`=0, `dout` reads 0.
- R2: During the second pulse in call style, the low vector byte is driven. With `interval4`=1 it is {vec_lo[2:0], level, 2'b00}. With `interval4`=0 it is {vec_lo[2:1], level, 3'b000}.
- R3: During the third pulse in call style, `vec_hi` is driven.
- R4: In pointer style (`ptr_mode`=1), the first pulse leaves `dout_oe`=0. The second pulse drives {vec_hi[7:3], level}.
- R5: `commit` pulses for one cycle on the first low cycle of the final pulse, and `commit_level` then carries the level.
- R6: When `aeoi`=1, `auto_eoi` pulses for one cycle on the first high cycle after the final pulse. `commit_level` still carries the level on that cycle.
- R7: A master (`single`=0, `is_master`=1) whose latched level has its `slave_map` bit set behaves as follows. It drives that level on `cas_out` from the cycle after the first pulse begins until the cycle after the final pulse ends. It does not drive vector bytes, although in call style it still drives the opcode.
- R8: A master whose latched level has no subordinate outputs `cas_out`=0 and drives the vector bytes itself. A standalone controller (`single`=1) does the same. `cas_oe`=1 for a master only.
- R9: A subordinate (`single`=0, `is_master`=0) never drives the opcode. It drives the vector or pointer bytes, and raises `commit`/`auto_eoi`, only while `cas_in` equals `my_id`.
- R10: With `buffered`=1, `buf_en_n` is low exactly on the cycles where `dout_oe`=1. With `buffered`=0, `buf_en_n` stays high.
- R11: If `req_valid` is low when the first pulse begins, the sequence uses level 7, and neither `commit` nor `auto_eoi` is raised.
- R12: `int_out` follows `req_valid` while the block is idle. It is held low from the cycle after the first pulse begins until the cycle after the final pulse ends. The block becomes idle after 2 pulses in pointer style and after 3 pulses in call style.
- R13: The level is captured when the first pulse begins. Later changes of `req_level` during the sequence do not alter the bytes, `cas_out` or `commit_level`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ack_n | input | 1 | Processor acknowledge, active low |
| req_valid | input | 1 | Resolver has an eligible request |
| req_level | input | 3 | Winning level from the resolver |
| ptr_mode | input | 1 | 1: pointer style, 0: call style |
| interval4 | input | 1 | Call address spacing 4 (1) or 8 (0) |
| vec_lo | input | 3 | Upper bits of the low vector byte |
| vec_hi | input | 8 | High vector byte / pointer base |
| single | input | 1 | Standalone, no cascade |
| is_master | input | 1 | Cascade role: 1 master, 0 subordinate |
| slave_map | input | 8 | Inputs that have a subordinate attached |
| my_id | input | 3 | Subordinate identifier |
| aeoi | input | 1 | Automatic end-of-interrupt enable |
| buffered | input | 1 | Buffer-enable output in use |
| cas_in | input | 3 | Cascade lines as seen on the pins |
| dout | output | 8 | Data byte |
| dout_oe | output | 1 | Data bus drive enable |
| buf_en_n | output | 1 | External transceiver enable, active low |
| cas_out | output | 3 | Cascade identifier driven by a master |
| cas_oe | output | 1 | Cascade line drive enable |
| int_out | output | 1 | Interrupt request to processor |
| commit | output | 1 | Mark level in service, clear its request |
| commit_level | output | 3 | Level for commit and auto_eoi |
| auto_eoi | output | 1 | Retire the level automatically |

## Verification
The end of a sequence can fall on the same cycle as a request that is still pending. On that cycle the counter wraps and `auto_eoi` fires, while `req_valid` has been held high throughout. The bench keeps `req_valid` asserted across whole sequences. It checks that `int_out` stays low on the wrap cycle, rises on the next cycle, and that `auto_eoi` and the return to idle happen together. It also changes `req_level` mid-sequence, so that a late winner cannot leak into the bytes of the sequence that is already under way.

// File: rtl/avs_pkg.sv
package avs_pkg;
    localparam int LVL_W = 3;
    localparam int NUM_IN = 1 << LVL_W;
    localparam int CNT_W = 2;
    localparam logic [7:0] CALL_OPCODE = 8'hCD;

    typedef enum logic [1:0] {
        ROLE_SINGLE = 2'd0,
        ROLE_MASTER = 2'd1,
        ROLE_SLAVE  = 2'd2
    } role_e;

    typedef struct packed {
        logic             ack_prev;
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic [LVL_W-1:0] lvl;
        logic             spur;
        logic             casc;
    } trk_t;
endpackage

// File: rtl/avs_tracker.sv
module avs_tracker
    import avs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ack_n,
    input  logic              ptr_mode,
    input  role_e             role,
    input  logic [NUM_IN-1:0] slave_map,
    input  logic              req_valid,
    input  logic [LVL_W-1:0]  req_level,
    input  logic              aeoi,
    input  logic              own_ok,
    output logic              busy,
    output logic [CNT_W-1:0]  cnt,
    output logic [LVL_W-1:0]  lvl,
    output logic              casc,
    output logic              commit,
    output logic              auto_eoi
);
    trk_t q, d;
    logic fall, rise, is_last;
    logic [CNT_W-1:0] last_idx;
    logic [LVL_W-1:0] start_lvl;

    always_comb begin
        d        = q;
        commit   = 1'b0;
        auto_eoi = 1'b0;
        fall      = q.ack_prev & ~ack_n;
        rise      = ~q.ack_prev & ack_n;
        last_idx  = ptr_mode ? CNT_W'(1) : CNT_W'(2);
        is_last   = (q.cnt == last_idx);
        start_lvl = req_valid ? req_level : {LVL_W{1'b1}};
        d.ack_prev = ack_n;
        if (fall) begin
            if (!q.busy) begin
                d.busy = 1'b1;
                d.cnt  = '0;
                d.lvl  = start_lvl;
                d.spur = ~req_valid;
                d.casc = (role == ROLE_MASTER) & slave_map[start_lvl];
            end else if (is_last && !q.spur && own_ok) begin
                commit = 1'b1;
            end
        end
        if (rise && q.busy) begin
            if (is_last) begin
                d.busy   = 1'b0;
                d.cnt    = '0;
                auto_eoi = aeoi & ~q.spur & own_ok;
            end else begin
                d.cnt = q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{ack_prev: 1'b1, busy: 1'b0, cnt: '0, lvl: '0, spur: 1'b0, casc: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign busy = q.busy;
    assign cnt  = q.cnt;
    assign lvl  = q.lvl;
    assign casc = q.casc;

    p_count_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CNT_W'(2));
    p_eoi_ends_seq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        auto_eoi |=> !q.busy);
    p_commit_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);
endmodule

// File: rtl/avs_cascade.sv
module avs_cascade
    import avs_pkg::*;
(
    input  role_e            role,
    input  logic             busy,
    input  logic             casc,
    input  logic [LVL_W-1:0] lvl,
    input  logic [LVL_W-1:0] cas_in,
    input  logic [LVL_W-1:0] my_id,
    output logic [LVL_W-1:0] cas_out,
    output logic             cas_oe,
    output logic             vec_ok,
    output logic             own_ok
);
    logic id_match;

    always_comb begin
        id_match = (cas_in == my_id);
        cas_oe   = (role == ROLE_MASTER);
        cas_out  = (busy && casc) ? lvl : '0;
        own_ok   = (role != ROLE_SLAVE) || id_match;
        unique case (role)
            ROLE_SINGLE: vec_ok = 1'b1;
            ROLE_MASTER: vec_ok = ~casc;
            ROLE_SLAVE:  vec_ok = id_match;
            default:     vec_ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/avs_bytegen.sv
module avs_bytegen
    import avs_pkg::*;
(
    input  logic             ack_n,
    input  logic             busy,
    input  logic [CNT_W-1:0] cnt,
    input  logic [LVL_W-1:0] lvl,
    input  logic             ptr_mode,
    input  logic             interval4,
    input  logic [2:0]       vec_lo,
    input  logic [7:0]       vec_hi,
    input  role_e            role,
    input  logic             vec_ok,
    output logic [7:0]       dout,
    output logic             dout_oe
);
    logic [CNT_W-1:0] idx;
    logic [7:0] lo_byte;

    always_comb begin
        idx     = busy ? cnt : '0;
        lo_byte = interval4 ? {vec_lo, lvl, 2'b00} : {vec_lo[2:1], lvl, 3'b000};
        dout    = 8'h00;
        dout_oe = 1'b0;
        if (!ack_n) begin
            if (ptr_mode) begin
                if (idx == CNT_W'(1) && vec_ok) begin
                    dout_oe = 1'b1;
                    dout    = {vec_hi[7:3], lvl};
                end
            end else begin
                case (idx)
                    CNT_W'(0): if (role != ROLE_SLAVE) begin
                        dout_oe = 1'b1;
                        dout    = CALL_OPCODE;
                    end
                    CNT_W'(1): if (vec_ok) begin
                        dout_oe = 1'b1;
                        dout    = lo_byte;
                    end
                    CNT_W'(2): if (vec_ok) begin
                        dout_oe = 1'b1;
                        dout    = vec_hi;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/ack_vector_seq.sv
module ack_vector_seq
    import avs_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ack_n,
    input  logic        req_valid,
    input  logic [2:0]  req_level,
    input  logic        ptr_mode,
    input  logic        interval4,
    input  logic [2:0]  vec_lo,
    input  logic [7:0]  vec_hi,
    input  logic        single,
    input  logic        is_master,
    input  logic [7:0]  slave_map,
    input  logic [2:0]  my_id,
    input  logic        aeoi,
    input  logic        buffered,
    input  logic [2:0]  cas_in,
    output logic [7:0]  dout,
    output logic        dout_oe,
    output logic        buf_en_n,
    output logic [2:0]  cas_out,
    output logic        cas_oe,
    output logic        int_out,
    output logic        commit,
    output logic [2:0]  commit_level,
    output logic        auto_eoi
);
    role_e            role;
    logic             busy, casc, vec_ok, own_ok;
    logic [CNT_W-1:0] cnt;
    logic [LVL_W-1:0] lvl;

    assign role = single ? ROLE_SINGLE : (is_master ? ROLE_MASTER : ROLE_SLAVE);

    avs_tracker u_trk (
        .clk(clk), .rst_n(rst_n), .ack_n(ack_n), .ptr_mode(ptr_mode),
        .role(role), .slave_map(slave_map), .req_valid(req_valid),
        .req_level(req_level), .aeoi(aeoi), .own_ok(own_ok),
        .busy(busy), .cnt(cnt), .lvl(lvl), .casc(casc),
        .commit(commit), .auto_eoi(auto_eoi)
    );

    avs_cascade u_cas (
        .role(role), .busy(busy), .casc(casc), .lvl(lvl),
        .cas_in(cas_in), .my_id(my_id), .cas_out(cas_out),
        .cas_oe(cas_oe), .vec_ok(vec_ok), .own_ok(own_ok)
    );

    avs_bytegen u_byte (
        .ack_n(ack_n), .busy(busy), .cnt(cnt), .lvl(lvl),
        .ptr_mode(ptr_mode), .interval4(interval4), .vec_lo(vec_lo),
        .vec_hi(vec_hi), .role(role), .vec_ok(vec_ok),
        .dout(dout), .dout_oe(dout_oe)
    );

    assign buf_en_n     = ~(buffered & dout_oe);
    assign int_out      = req_valid & ~busy;
    assign commit_level = lvl;

    p_int_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !int_out);
    p_oe_needs_ack_r1: assert property (@(posedge clk) disable iff (!rst_n)
        dout_oe |-> !ack_n);
    p_cas_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cas_out));
    p_slave_no_opcode_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (role == ROLE_SLAVE && dout_oe) |-> (busy && cnt != '0));
endmodule

// File: tb/tb_ack_vector_seq.sv
`timescale 1ns/1ps
module tb_ack_vector_seq;
    logic clk = 1'b0;
    logic rst_n, ack_n, req_valid, ptr_mode, interval4, single, is_master, aeoi, buffered;
    logic [2:0] req_level, vec_lo, my_id, cas_in;
    logic [7:0] vec_hi, slave_map;
    logic [7:0] dout;
    logic dout_oe, buf_en_n, cas_oe, int_out, commit, auto_eoi;
    logic [2:0] cas_out, commit_level;

    always #10 clk = ~clk;

    ack_vector_seq dut (
        .clk(clk), .rst_n(rst_n), .ack_n(ack_n), .req_valid(req_valid),
        .req_level(req_level), .ptr_mode(ptr_mode), .interval4(interval4),
        .vec_lo(vec_lo), .vec_hi(vec_hi), .single(single), .is_master(is_master),
        .slave_map(slave_map), .my_id(my_id), .aeoi(aeoi), .buffered(buffered),
        .cas_in(cas_in), .dout(dout), .dout_oe(dout_oe), .buf_en_n(buf_en_n),
        .cas_out(cas_out), .cas_oe(cas_oe), .int_out(int_out), .commit(commit),
        .commit_level(commit_level), .auto_eoi(auto_eoi)
    );

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // behavioural reference state
    int m_prev = 1, m_busy = 0, m_pulses = 0, m_lvl = 0, m_spur = 0, m_casc = 0;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        int r, last, idx, sel, vok, e_oe, e_dout, fall, rise, e_cm, e_eoi;
        string t;
        r    = single ? 0 : (is_master ? 1 : 2);
        last = ptr_mode ? 1 : 2;
        idx  = m_busy ? m_pulses : 0;
        sel  = (r == 2) ? (cas_in == my_id) : 1;
        vok  = (r == 0) || (r == 1 && !m_casc) || (r == 2 && cas_in == my_id);
        e_oe = 0; e_dout = 0;
        if (!ack_n) begin
            if (ptr_mode) begin
                if (idx == 1 && vok) begin e_oe = 1; e_dout = (vec_hi & 8'hF8) | m_lvl; end
            end else if (idx == 0) begin
                if (r != 2) begin e_oe = 1; e_dout = 8'hCD; end
            end else if (vok) begin
                e_oe = 1;
                if (idx == 1)
                    e_dout = interval4 ? (vec_lo * 32 + m_lvl * 4) : ((vec_lo >> 1) * 64 + m_lvl * 8);
                else
                    e_dout = vec_hi;
            end
        end
        fall  = m_prev && !ack_n;
        rise  = !m_prev && ack_n;
        e_cm  = rst_n && fall && m_busy && m_pulses == last && !m_spur && sel;
        e_eoi = rst_n && rise && m_busy && m_pulses == last && aeoi && !m_spur && sel;
        if (m_spur && m_busy) t = "R11";
        else if (m_busy && req_level != m_lvl) t = "R13";
        else if (ptr_mode) t = "R4";
        else if (idx == 0) t = "R1";
        else if (idx == 1) t = "R2";
        else t = "R3";
        chk({t, " dout"}, dout, e_dout);
        chk((r == 2) ? "R9 dout_oe" : (m_casc ? "R7 dout_oe" : "R8 dout_oe"), dout_oe, e_oe);
        chk(m_spur ? "R11 commit" : "R5 commit", commit, e_cm);
        chk(m_spur ? "R11 auto_eoi" : "R6 auto_eoi", auto_eoi, e_eoi);
        if (e_cm || e_eoi) chk("R13 commit_level", commit_level, m_lvl);
        chk(m_casc ? "R7 cas_out" : "R8 cas_out", cas_out, (m_busy && m_casc) ? m_lvl : 0);
        chk("R8 cas_oe", cas_oe, r == 1);
        chk("R10 buf_en_n", buf_en_n, !(buffered && e_oe));
        chk("R12 int_out", int_out, req_valid && !m_busy);
    endtask

    task automatic update();
        int last, fall, rise, sl;
        last = ptr_mode ? 1 : 2;
        fall = m_prev && !ack_n;
        rise = !m_prev && ack_n;
        if (!rst_n) begin
            m_prev = 1; m_busy = 0; m_pulses = 0; m_lvl = 0; m_spur = 0; m_casc = 0;
            return;
        end
        if (fall && !m_busy) begin
            m_busy = 1; m_pulses = 0;
            m_spur = !req_valid;
            m_lvl  = req_valid ? req_level : 7;
            sl     = slave_map[m_lvl];
            m_casc = (!single && is_master && sl) ? 1 : 0;
        end
        if (rise && m_busy) begin
            if (m_pulses == last) begin m_busy = 0; m_pulses = 0; end
            else m_pulses++;
        end
        m_prev = ack_n;
    endtask

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            #5;
            compare();
            @(posedge clk);
            update();
            @(negedge clk);
        end
    endtask

    task automatic pulse();
        ack_n = 1'b0; step(2);
        ack_n = 1'b1; step(2);
    endtask

    task automatic sequence_run(int lvl, int mid_lvl);
        req_valid = 1'b1; req_level = 3'(lvl);
        step(2);
        pulse();
        if (mid_lvl >= 0) req_level = 3'(mid_lvl);
        pulse();
        if (!ptr_mode) pulse();
        step(2);
    endtask

    initial begin
        for (int c = 0; c < 20000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            fails++; checks++;
            $display("FAIL R12 watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 0; ack_n = 1; req_valid = 0; req_level = 0; ptr_mode = 0; interval4 = 1;
        vec_lo = 3'b101; vec_hi = 8'h9A; single = 1; is_master = 0; slave_map = 0;
        my_id = 0; aeoi = 0; buffered = 0; cas_in = 0;
        @(negedge clk);
        step(3);                                 // reset state
        rst_n = 1; step(2);
        sequence_run(5, -1);                     // R1 R2 R3 call, interval 4
        interval4 = 0; aeoi = 1; vec_lo = 3'b110;
        sequence_run(2, -1);                     // R2 interval 8, R6
        ptr_mode = 1; buffered = 1; vec_hi = 8'hB3;
        sequence_run(6, -1);                     // R4 R10
        single = 0; is_master = 1; ptr_mode = 0; slave_map = 8'b0000_1000;
        sequence_run(3, -1);                     // R7 master with subordinate
        sequence_run(0, -1);                     // R8 master without subordinate
        ptr_mode = 1;
        sequence_run(3, -1);                     // R7 pointer style
        is_master = 0; my_id = 3'd4; cas_in = 3'd4;
        sequence_run(1, -1);                     // R9 selected
        cas_in = 3'd2;
        sequence_run(1, -1);                     // R9 not selected
        ptr_mode = 0; cas_in = 3'd4;
        sequence_run(7, -1);                     // R9 call style
        single = 1; req_valid = 0; step(2);
        pulse(); pulse(); pulse(); step(2);      // R11 spurious
        buffered = 0;
        sequence_run(4, 1);                      // R13 mid-sequence change, R12 pending
        req_valid = 0; step(3);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule